// File: doc/BRIEF.md
# Indirect Register Window Bridge

This bridge sits on a 32-bit memory-mapped host bus and gives software access to a separate internal 32-bit register space. Software never addresses the internal registers directly. Instead it uses three host-visible window registers: a command register, a write-data register and a read-result register. Each internal access is a two-step transaction.

To write an internal register, software first loads the write-data register. It then writes the command register with the start bit set, the direction bit set and the target address. To read an internal register, software writes the command register with the start bit set, the direction bit clear and the address. It then polls the start bit until it clears and reads the result register.

The internal side is a valid/ready request port. The bridge holds one request on that port until the target accepts it. For a read, the bridge captures the target's response data at the accepting edge.

Top module: `iwin_bridge`

## Requirements
- R1: Host offsets are 0x100 (command), 0x104 (write data) and 0x108 (read result). A read of any other offset returns 0, and a write to any other offset changes nothing.
- R2: A command write with bit 31 set while idle starts one access. From the next cycle `tgt_valid_o` is 1, `tgt_addr_o` equals command bits [7:0] and `tgt_write_o` equals command bit 8 (1 = write, 0 = read).
- R3: For a write access, `tgt_wdata_o` equals the write-data register value at the moment the start was accepted. It stays at that value even if the write-data register is rewritten during the access.
- R4: `tgt_valid_o`, `tgt_addr_o`, `tgt_write_o` and `tgt_wdata_o` hold steady until a cycle with `tgt_ready_i` high. The access completes on that edge, and `tgt_valid_o` is 0 from the next cycle.
- R5: When a read access completes, `tgt_rdata_i` is stored in the read-result register. A completed write access leaves the read-result register unchanged.
- R6: The command register reads back as {busy at bit 31, zeros, direction at bit 8, address at [7:0]}. Bit 31 is 1 while an access is pending and 0 after it completes.
- R7: A command write that arrives while an access is pending is ignored completely. The address, direction and write data of the pending access do not change.
- R8: A command write with bit 31 clear while idle updates the readback direction and address fields but starts no access.
- R9: Host writes to the read-result register are ignored.
- R10: Reset clears all three window registers, deasserts `tgt_valid_o` and returns the sequencer to idle, including in the middle of an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_sel_i | input | 1 | Host access strobe |
| host_wr_i | input | 1 | Host direction: 1 = write, 0 = read |
| host_addr_i | input | 12 | Host byte offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data (combinational) |
| tgt_valid_o | output | 1 | Internal request valid |
| tgt_write_o | output | 1 | Internal request direction: 1 = write |
| tgt_addr_o | output | 8 | Internal register address |
| tgt_wdata_o | output | 32 | Internal write data |
| tgt_ready_i | input | 1 | Target accepts the request and its response is valid |
| tgt_rdata_i | input | 32 | Target read response data |

## Verification
The hardest situation to reach from the ports is host activity that collides with a pending access. Examples are a second start command, or a rewrite of the write-data register, issued while the target is still withholding ready. To reach these states, the bench plays the target itself. It holds `tgt_ready_i` low for a chosen number of cycles and issues host writes inside that window. Reset is also asserted inside such a window, so the bench can observe that the pending request is abandoned.

// File: rtl/iwin_pkg.sv
package iwin_pkg;
  localparam int NWIN     = 3;
  localparam int IDX_CTRL = 0;
  localparam int IDX_DIN  = 1;
  localparam int IDX_DOUT = 2;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_REQ  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/iwin_decode.sv
module iwin_decode
  import iwin_pkg::*;
#(
  parameter int                 HADDR_W  = 12,
  parameter logic [HADDR_W-1:0] CTRL_OFS = 12'h100,
  parameter logic [HADDR_W-1:0] DIN_OFS  = 12'h104,
  parameter logic [HADDR_W-1:0] DOUT_OFS = 12'h108
) (
  input  logic               host_sel_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  output logic [NWIN-1:0]    hit_o
);
  localparam logic [HADDR_W-1:0] OFS [NWIN] = '{CTRL_OFS, DIN_OFS, DOUT_OFS};

  for (genvar g = 0; g < NWIN; g++) begin : g_hit
    assign hit_o[g] = host_sel_i && (host_addr_i == OFS[g]);
  end
endmodule

// File: rtl/iwin_seq.sv
module iwin_seq
  import iwin_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TADDR_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ctrl_we_i,
  input  logic               go_i,
  input  logic               dir_i,
  input  logic [TADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]  din_i,
  input  logic               tgt_ready_i,
  output logic               tgt_valid_o,
  output logic               tgt_write_o,
  output logic [TADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0]  tgt_wdata_o,
  output logic               done_rd_o,
  output logic [DATA_W-1:0]  ctrl_word_o
);
  localparam int BUSY_BIT = DATA_W - 1;
  localparam int DIR_BIT  = TADDR_W;

  seq_state_e         state_q;
  logic               dir_q;
  logic [TADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               busy;

  assign busy = (state_q == ST_REQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      dir_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ctrl_we_i) begin
            dir_q  <= dir_i;
            addr_q <= addr_i;
            if (go_i) begin
              wdata_q <= din_i;  // snapshot: later data-in writes do not disturb the request
              state_q <= ST_REQ;
            end
          end
        end
        ST_REQ: if (tgt_ready_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign tgt_valid_o = busy;
  assign tgt_write_o = dir_q;
  assign tgt_addr_o  = addr_q;
  assign tgt_wdata_o = wdata_q;
  assign done_rd_o   = busy && tgt_ready_i && !dir_q;

  always_comb begin
    ctrl_word_o                = '0;
    ctrl_word_o[BUSY_BIT]      = busy;
    ctrl_word_o[DIR_BIT]       = dir_q;
    ctrl_word_o[TADDR_W-1:0]   = addr_q;
  end

  assert_start_from_cmd_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tgt_valid_o) |-> $past(ctrl_we_i && go_i));

  assert_req_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && !tgt_ready_i) |=> (tgt_valid_o && $stable(tgt_addr_o)
      && $stable(tgt_write_o) && $stable(tgt_wdata_o)));

  assert_req_drop_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && tgt_ready_i) |=> !tgt_valid_o);

  assert_busy_cmd_ignored_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tgt_valid_o && ctrl_we_i) |=> ($stable(tgt_addr_o) && $stable(tgt_write_o)
      && $stable(tgt_wdata_o)));
endmodule

// File: rtl/iwin_regs.sv
module iwin_regs
  import iwin_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NWIN-1:0]   hit_i,
  input  logic              host_wr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [DATA_W-1:0] ctrl_word_i,
  input  logic              done_rd_i,
  input  logic [DATA_W-1:0] tgt_rdata_i,
  output logic [DATA_W-1:0] din_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] din_q;
  logic [DATA_W-1:0] dout_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q  <= '0;
      dout_q <= '0;
    end else begin
      if (hit_i[IDX_DIN] && host_wr_i) din_q <= host_wdata_i;
      if (done_rd_i) dout_q <= tgt_rdata_i;  // host writes to data-out have no path here
    end
  end

  assign din_o = din_q;

  always_comb begin
    rdata_o = '0;
    if (!host_wr_i) begin
      if (hit_i[IDX_CTRL])      rdata_o = ctrl_word_i;
      else if (hit_i[IDX_DIN])  rdata_o = din_q;
      else if (hit_i[IDX_DOUT]) rdata_o = dout_q;
    end
  end

  assert_dout_capture_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_rd_i |=> (dout_q == $past(tgt_rdata_i)));

  assert_dout_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_rd_i |=> $stable(dout_q));
endmodule

// File: rtl/iwin_bridge.sv
module iwin_bridge
  import iwin_pkg::*;
#(
  parameter int                 HADDR_W  = 12,
  parameter int                 DATA_W   = 32,
  parameter int                 TADDR_W  = 8,
  parameter logic [HADDR_W-1:0] CTRL_OFS = 12'h100,
  parameter logic [HADDR_W-1:0] DIN_OFS  = 12'h104,
  parameter logic [HADDR_W-1:0] DOUT_OFS = 12'h108
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_sel_i,
  input  logic               host_wr_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0]  host_wdata_i,
  output logic [DATA_W-1:0]  host_rdata_o,
  output logic               tgt_valid_o,
  output logic               tgt_write_o,
  output logic [TADDR_W-1:0] tgt_addr_o,
  output logic [DATA_W-1:0]  tgt_wdata_o,
  input  logic               tgt_ready_i,
  input  logic [DATA_W-1:0]  tgt_rdata_i
);
  localparam int GO_BIT  = DATA_W - 1;
  localparam int DIR_BIT = TADDR_W;

  logic [NWIN-1:0]   hit;
  logic [DATA_W-1:0] din;
  logic [DATA_W-1:0] ctrl_word;
  logic              done_rd;

  iwin_decode #(
    .HADDR_W (HADDR_W),
    .CTRL_OFS(CTRL_OFS),
    .DIN_OFS (DIN_OFS),
    .DOUT_OFS(DOUT_OFS)
  ) u_decode (
    .host_sel_i (host_sel_i),
    .host_addr_i(host_addr_i),
    .hit_o      (hit)
  );

  iwin_seq #(
    .DATA_W (DATA_W),
    .TADDR_W(TADDR_W)
  ) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctrl_we_i  (hit[IDX_CTRL] && host_wr_i),
    .go_i       (host_wdata_i[GO_BIT]),
    .dir_i      (host_wdata_i[DIR_BIT]),
    .addr_i     (host_wdata_i[TADDR_W-1:0]),
    .din_i      (din),
    .tgt_ready_i(tgt_ready_i),
    .tgt_valid_o(tgt_valid_o),
    .tgt_write_o(tgt_write_o),
    .tgt_addr_o (tgt_addr_o),
    .tgt_wdata_o(tgt_wdata_o),
    .done_rd_o  (done_rd),
    .ctrl_word_o(ctrl_word)
  );

  iwin_regs #(
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .hit_i       (hit),
    .host_wr_i   (host_wr_i),
    .host_wdata_i(host_wdata_i),
    .ctrl_word_i (ctrl_word),
    .done_rd_i   (done_rd),
    .tgt_rdata_i (tgt_rdata_i),
    .din_o       (din),
    .rdata_o     (host_rdata_o)
  );
endmodule

// File: tb/iwin_bridge_bench.sv
`timescale 1ns/1ps
module iwin_bridge_bench;
  localparam logic [11:0] A_CTRL = 12'h100;
  localparam logic [11:0] A_DIN  = 12'h104;
  localparam logic [11:0] A_DOUT = 12'h108;

  // {write(1), addr(8), data(32), latency(4)}
  localparam int NV = 6;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 8'h04, 32'hDEAD_BEEF, 4'd0},
    {1'b0, 8'h04, 32'h1234_5678, 4'd2},
    {1'b1, 8'hFF, 32'hA5A5_5A5A, 4'd3},
    {1'b0, 8'h00, 32'hFFFF_FFFF, 4'd0},
    {1'b0, 8'h80, 32'h0000_0001, 4'd5},
    {1'b1, 8'h3C, 32'h0000_0000, 4'd1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_sel = 1'b0;
  logic        host_wr = 1'b0;
  logic [11:0] host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        tgt_valid;
  logic        tgt_write;
  logic [7:0]  tgt_addr;
  logic [31:0] tgt_wdata;
  logic        tgt_ready = 1'b0;
  logic [31:0] tgt_rdata = '0;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] exp_dout = '0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  iwin_bridge u_iwin_bridge (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .host_sel_i  (host_sel),
    .host_wr_i   (host_wr),
    .host_addr_i (host_addr),
    .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata),
    .tgt_valid_o (tgt_valid),
    .tgt_write_o (tgt_write),
    .tgt_addr_o  (tgt_addr),
    .tgt_wdata_o (tgt_wdata),
    .tgt_ready_i (tgt_ready),
    .tgt_rdata_i (tgt_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_sel = 1'b0; host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [11:0] a, output logic [31:0] d);
    host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
    #1 d = host_rdata;
    host_sel = 1'b0;
  endtask

  task automatic respond(input logic [31:0] d);
    tgt_ready = 1'b1; tgt_rdata = d;
    @(negedge clk);
    tgt_ready = 1'b0; tgt_rdata = '0;
  endtask

  function automatic logic [31:0] cmd(input logic go, input logic w, input logic [7:0] a);
    return {go, 22'b0, w, a};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 valid", {31'b0, tgt_valid}, 32'h0);
    hrd(A_CTRL, rd); chk("R10 ctrl", rd, 32'h0);
    hrd(A_DIN, rd);  chk("R10 din", rd, 32'h0);
    hrd(A_DOUT, rd); chk("R10 dout", rd, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic        w  = VEC[i][44];
      logic [7:0]  a  = VEC[i][43:36];
      logic [31:0] d  = VEC[i][35:4];
      int          lt = int'(VEC[i][3:0]);
      if (w) hwr(A_DIN, d);
      hwr(A_CTRL, cmd(1'b1, w, a));
      chk("R2 valid", {31'b0, tgt_valid}, 32'h1);
      chk("R2 addr", {24'b0, tgt_addr}, {24'b0, a});
      chk("R2 dir", {31'b0, tgt_write}, {31'b0, w});
      if (w) chk("R3 wdata", tgt_wdata, d);
      hrd(A_CTRL, rd); chk("R6 busy readback", rd, cmd(1'b1, w, a));
      for (int k = 0; k < lt; k++) begin
        @(negedge clk);
        chk("R4 valid held", {31'b0, tgt_valid}, 32'h1);
        chk("R4 addr held", {24'b0, tgt_addr}, {24'b0, a});
      end
      respond(w ? ~d : d);
      chk("R4 valid dropped", {31'b0, tgt_valid}, 32'h0);
      hrd(A_CTRL, rd); chk("R6 go cleared", rd, cmd(1'b0, w, a));
      if (!w) exp_dout = d;
      hrd(A_DOUT, rd); chk("R5 dout", rd, exp_dout);
    end

    // R7: start while busy is ignored
    hwr(A_CTRL, cmd(1'b1, 1'b0, 8'h10));
    hwr(A_CTRL, cmd(1'b1, 1'b1, 8'h20));
    chk("R7 addr kept", {24'b0, tgt_addr}, 32'h10);
    chk("R7 dir kept", {31'b0, tgt_write}, 32'h0);
    respond(32'h7777_0000);
    exp_dout = 32'h7777_0000;
    hrd(A_CTRL, rd); chk("R7 ctrl after", rd, cmd(1'b0, 1'b0, 8'h10));
    @(negedge clk);
    chk("R7 no second access", {31'b0, tgt_valid}, 32'h0);

    // R3: data-in rewrite during a write access
    hwr(A_DIN, 32'h1111_1111);
    hwr(A_CTRL, cmd(1'b1, 1'b1, 8'h21));
    hwr(A_DIN, 32'h2222_2222);
    chk("R3 wdata snapshot", tgt_wdata, 32'h1111_1111);
    hrd(A_DIN, rd); chk("R3 din updated", rd, 32'h2222_2222);
    respond(32'h0);
    hrd(A_DOUT, rd); chk("R5 dout after write", rd, exp_dout);

    // R8: command without go
    hwr(A_CTRL, cmd(1'b0, 1'b1, 8'h55));
    chk("R8 no access", {31'b0, tgt_valid}, 32'h0);
    hrd(A_CTRL, rd); chk("R8 fields", rd, 32'h0000_0155);
    @(negedge clk);
    chk("R8 still idle", {31'b0, tgt_valid}, 32'h0);

    // R9: data-out write ignored
    hwr(A_DOUT, 32'hCAFE_F00D);
    hrd(A_DOUT, rd); chk("R9 dout", rd, exp_dout);

    // R1: unmapped offsets
    hrd(12'h10C, rd); chk("R1 unmapped read", rd, 32'h0);
    hwr(12'h000, cmd(1'b1, 1'b1, 8'h99));
    chk("R1 unmapped write no access", {31'b0, tgt_valid}, 32'h0);
    hrd(A_CTRL, rd); chk("R1 ctrl unchanged", rd, 32'h0000_0155);
    hrd(A_DIN, rd);  chk("R1 din unchanged", rd, 32'h2222_2222);

    // R10: reset mid-access
    hwr(A_CTRL, cmd(1'b1, 1'b0, 8'h42));
    chk("R10 pre busy", {31'b0, tgt_valid}, 32'h1);
    rst_n = 1'b0;
    #1;
    chk("R10 valid cleared", {31'b0, tgt_valid}, 32'h0);
    hrd(A_CTRL, rd); chk("R10 ctrl cleared", rd, 32'h0);
    hrd(A_DIN, rd);  chk("R10 din cleared", rd, 32'h0);
    hrd(A_DOUT, rd); chk("R10 dout cleared", rd, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after", {31'b0, tgt_valid}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule